// File: doc/BRIEF.md
# Packed SIMD lane ALU

This block performs one lane-parallel operation per cycle on a 64-bit word. The word is split either into eight unsigned 8-bit lanes or into four signed 16-bit lanes. The second operand can be a whole vector. It can also be one element of a vector copied to every lane, or a small zero-extended immediate copied to every lane. A five-bit format/select field chooses both the lane format and the operand source.

Three kinds of operation share the datapath. An ALU operation writes a lane-wise result: bitwise logic, shifts, saturating add/sub/multiply, min/max, and operations that exist in only one format. A compare operation writes one flag per lane. A pick operation merges the two operands lane by lane, steered by a flag vector that the caller supplies. Everything is computed combinationally, and a single register stage captures it. An opcode that the current format does not define raises an illegal indication and leaves the result register untouched.

Top module: `simd_lane_alu`

## Requirements
- R1: After reset, `result`, `flags_out`, `illegal` and `out_valid` are all 0. `out_valid` is `in_valid` delayed by one clock, and every output reflects the operation presented on the previous edge. `op_kind` encodes the kind of operation: 0 is ALU, 1 is compare, 2 is pick, and 3 changes neither `result` nor `flags_out`.
- R2: `fmtsel[0]` selects the lane format. 0 gives eight unsigned bytes, lane i at bits 8i+7:8i. 1 gives four signed halfwords, lane i at bits 16i+15:16i.
- R3: The second operand source is decoded from `fmtsel[4:3]`. 0x selects a broadcast element of `src_b`. 10 selects `src_b` as a full vector. 11 selects `imm`, zero-extended and copied to every lane.
- R4: The broadcast element index is `fmtsel[3:1]` in byte mode and `fmtsel[3:2]` in halfword mode.
- R5: The opcode values are: 0 and, 1 nor, 2 or, 3 xor, 4 shift left, 5 logical shift right, 6 add, 7 sub, 8 min, 9 max, 10 mul, 11 multiply-by-sign, 12 arithmetic shift right, 13 absolute difference, 14 average. The four logic operations act bitwise in either format.
- R6: Shift counts use the low 3 bits of the lane's second operand in byte mode and the low 4 bits in halfword mode. Arithmetic shift right fills with the sign bit.
- R7: Add, sub and mul saturate to 0..255 in byte mode and to -32768..32767 in halfword mode. A negative byte difference gives 0.
- R8: Min and max compare unsigned in byte mode and signed in halfword mode.
- R9: Multiply-by-sign (halfword only) works on each lane. It returns 0 when A is 0 and B when A is positive. When A is negative it returns -B, except that B = -32768 gives +32767.
- R10: Absolute difference |A-B| and average (A+B+1)>>1 are byte-only. The average never overflows.
- R11: Some ALU opcodes are not defined for the current format: 11, 12 and 15 in byte mode, and 13, 14 and 15 in halfword mode. For these, `illegal` is 1 in the output cycle and `result` keeps its previous value. `illegal` is 0 after every other cycle.
- R12: A compare sets flag i when (`cond_eq` and A=B) or (`cond_lt` and A<B). The comparison is unsigned for bytes and signed for halfwords. In halfword mode flags 7:4 are 0. No other kind changes `flags_out`.
- R13: A pick takes lane i from `src_a` when `flag_in[i]` equals `pick_tf`, and from the selected second operand otherwise. Halfword lanes use `flag_in[3:0]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Operation present this cycle |
| op_kind | input | 2 | 0 ALU, 1 compare, 2 pick, 3 none |
| opcode | input | 4 | ALU operation code |
| fmtsel | input | 5 | Lane format and operand source select |
| src_a | input | 64 | First operand vector |
| src_b | input | 64 | Second operand vector / element source |
| imm | input | 5 | Immediate for the broadcast source |
| cond_eq | input | 1 | Compare: flag on equality |
| cond_lt | input | 1 | Compare: flag on less-than |
| flag_in | input | 8 | Per-lane condition flags for pick |
| pick_tf | input | 1 | Flag value that selects `src_a` |
| out_valid | output | 1 | Registered valid |
| result | output | 64 | Registered lane result |
| flags_out | output | 8 | Registered compare flags |
| illegal | output | 1 | Last ALU opcode was undefined for its format |

## Verification
The bench builds the block with its defaults, DATA_W = 64 and IMM_W = 5. That gives eight byte lanes and four halfword lanes, and every element index that `fmtsel` can encode lands inside the word. With the full 5-bit immediate, every value 0..31 can reach both lane widths, which covers the byte shift counts beyond 7 and the halfword shift counts beyond 15 that the counts must wrap. Random draws of `fmtsel` reach all three operand sources and both formats for every opcode, including the undefined ones. Directed cases pin the saturation edges and the negation of -32768.

// File: rtl/simd_alu_pkg.sv
// Shared types for the packed SIMD lane ALU.
// Assumes: the operand word is a multiple of 16 bits.
package simd_alu_pkg;

    typedef enum logic [3:0] {
        OP_AND  = 4'd0,
        OP_NOR  = 4'd1,
        OP_OR   = 4'd2,
        OP_XOR  = 4'd3,
        OP_SLL  = 4'd4,
        OP_SRL  = 4'd5,
        OP_ADD  = 4'd6,
        OP_SUB  = 4'd7,
        OP_MIN  = 4'd8,
        OP_MAX  = 4'd9,
        OP_MUL  = 4'd10,
        OP_MSGN = 4'd11,
        OP_SRA  = 4'd12,
        OP_ABSD = 4'd13,
        OP_AVG  = 4'd14,
        OP_RSVD = 4'd15
    } lane_op_e;

    typedef enum logic [1:0] {
        K_ALU  = 2'd0,
        K_CMP  = 2'd1,
        K_PICK = 2'd2,
        K_NONE = 2'd3
    } op_kind_e;

    typedef enum logic [1:0] {
        SRC_ELEM = 2'd0,
        SRC_VEC  = 2'd1,
        SRC_IMM  = 2'd2
    } src_sel_e;

    // Maps the upper select bits onto an operand source.
    function automatic src_sel_e decode_src(input logic [1:0] hi_bits);
        if (!hi_bits[1])     return SRC_ELEM;
        else if (!hi_bits[0]) return SRC_VEC;
        else                  return SRC_IMM;
    endfunction

    // Clamps a wide signed value into the signed 16-bit range.
    function automatic logic [15:0] sat16(input logic signed [31:0] v);
        if (v > 32'sd32767)       return 16'h7FFF;
        else if (v < -32'sd32768) return 16'h8000;
        else                      return v[15:0];
    endfunction

endpackage

// File: rtl/simd_operand_sel.sv
// Builds the second operand for every lane of both formats.
// Source: the full vector, one element of it copied to all lanes,
// or the zero-extended immediate copied to all lanes.
// Assumes DATA_W = 64, so that the 3-bit and 2-bit element indices
// cover the word exactly.
module simd_operand_sel
    import simd_alu_pkg::*;
#(
    parameter int DATA_W = 64,
    parameter int IMM_W  = 5
) (
    input  logic [4:0]        fmtsel,
    input  logic [DATA_W-1:0] vec,
    input  logic [IMM_W-1:0]  imm,
    output logic [DATA_W-1:0] opb
);
    localparam int B_LANES = DATA_W / 8;
    localparam int H_LANES = DATA_W / 16;

    logic [7:0]        elem_b;
    logic [15:0]       elem_h;
    logic [DATA_W-1:0] bcast_b, bcast_h, imm_b, imm_h;
    logic [DATA_W-1:0] bcast, immv;

    // Fetch the indexed element for each lane width.
    always_comb begin
        elem_b = vec[{fmtsel[3:1], 3'b000} +: 8];
        elem_h = vec[{fmtsel[3:2], 4'b0000} +: 16];
    end

    for (genvar g = 0; g < B_LANES; g++) begin : g_brep
        assign bcast_b[g*8 +: 8] = elem_b;
        assign imm_b[g*8 +: 8]   = 8'(imm);
    end

    for (genvar g = 0; g < H_LANES; g++) begin : g_hrep
        assign bcast_h[g*16 +: 16] = elem_h;
        assign imm_h[g*16 +: 16]   = 16'(imm);
    end

    // Pick the replicated form matching the lane format.
    always_comb begin
        bcast = fmtsel[0] ? bcast_h : bcast_b;
        immv  = fmtsel[0] ? imm_h   : imm_b;
    end

    // Choose the operand source from the upper select bits.
    always_comb begin
        case (decode_src(fmtsel[4:3]))
            SRC_VEC: opb = vec;
            SRC_IMM: opb = immv;
            default: opb = bcast;
        endcase
    end

endmodule

// File: rtl/simd_byte_lane.sv
// One unsigned 8-bit lane of the ALU.
// Flags as not legal the opcodes that byte mode does not define.
// Purely combinational.
module simd_byte_lane
    import simd_alu_pkg::*;
(
    input  lane_op_e   op,
    input  logic [7:0] a,
    input  logic [7:0] b,
    output logic [7:0] y,
    output logic       legal
);
    logic [8:0]  sum9;
    logic [8:0]  avg9;
    logic [15:0] prod;

    // Wide intermediates for the saturating and averaging paths.
    always_comb begin
        sum9 = {1'b0, a} + {1'b0, b};
        avg9 = sum9 + 9'd1;
        prod = 16'(a) * 16'(b);
    end

    // Lane operation decode.
    always_comb begin
        legal = 1'b1;
        y     = 8'h00;
        case (op)
            OP_AND:  y = a & b;
            OP_NOR:  y = ~(a | b);
            OP_OR:   y = a | b;
            OP_XOR:  y = a ^ b;
            OP_SLL:  y = a << b[2:0];
            OP_SRL:  y = a >> b[2:0];
            OP_ADD:  y = sum9[8] ? 8'hFF : sum9[7:0];
            OP_SUB:  y = (a < b) ? 8'h00 : a - b;
            OP_MIN:  y = (a < b) ? a : b;
            OP_MAX:  y = (a > b) ? a : b;
            OP_MUL:  y = (prod > 16'd255) ? 8'hFF : prod[7:0];
            OP_ABSD: y = (a >= b) ? a - b : b - a;
            OP_AVG:  y = avg9[8:1];
            default: legal = 1'b0;
        endcase
    end

endmodule

// File: rtl/simd_half_lane.sv
// One signed 16-bit lane of the ALU.
// Flags as not legal the opcodes that halfword mode does not define.
// Purely combinational.
module simd_half_lane
    import simd_alu_pkg::*;
(
    input  lane_op_e    op,
    input  logic [15:0] a,
    input  logic [15:0] b,
    output logic [15:0] y,
    output logic        legal
);
    logic signed [16:0] sum17, dif17;
    logic signed [31:0] prod32;
    logic [15:0]        msgn_y;

    // Extended-width arithmetic feeding the clamps.
    always_comb begin
        sum17  = $signed({a[15], a}) + $signed({b[15], b});
        dif17  = $signed({a[15], a}) - $signed({b[15], b});
        prod32 = $signed(a) * $signed(b);
    end

    // Multiply-by-sign: the sign of A steers B, negation saturates.
    always_comb begin
        if (a == 16'h0000)      msgn_y = 16'h0000;
        else if (!a[15])        msgn_y = b;
        else if (b == 16'h8000) msgn_y = 16'h7FFF;
        else                    msgn_y = 16'h0000 - b;
    end

    // Lane operation decode.
    always_comb begin
        legal = 1'b1;
        y     = 16'h0000;
        case (op)
            OP_AND:  y = a & b;
            OP_NOR:  y = ~(a | b);
            OP_OR:   y = a | b;
            OP_XOR:  y = a ^ b;
            OP_SLL:  y = a << b[3:0];
            OP_SRL:  y = a >> b[3:0];
            OP_SRA:  y = 16'($signed(a) >>> b[3:0]);
            OP_ADD:  y = sat16(32'(sum17));
            OP_SUB:  y = sat16(32'(dif17));
            OP_MIN:  y = ($signed(a) < $signed(b)) ? a : b;
            OP_MAX:  y = ($signed(a) > $signed(b)) ? a : b;
            OP_MUL:  y = sat16(prod32);
            OP_MSGN: y = msgn_y;
            default: legal = 1'b0;
        endcase
    end

endmodule

// File: rtl/simd_lane_alu.sv
// Packed SIMD lane ALU, top level.
// Evaluates ALU, compare and pick for both lane formats in parallel.
// Selects by the format bit and captures the chosen outcome in one
// register stage. Assumes DATA_W = 64 (see simd_operand_sel).
module simd_lane_alu
    import simd_alu_pkg::*;
#(
    parameter int DATA_W = 64,
    parameter int IMM_W  = 5
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  in_valid,
    input  logic [1:0]            op_kind,
    input  logic [3:0]            opcode,
    input  logic [4:0]            fmtsel,
    input  logic [DATA_W-1:0]     src_a,
    input  logic [DATA_W-1:0]     src_b,
    input  logic [IMM_W-1:0]      imm,
    input  logic                  cond_eq,
    input  logic                  cond_lt,
    input  logic [DATA_W/8-1:0]   flag_in,
    input  logic                  pick_tf,
    output logic                  out_valid,
    output logic [DATA_W-1:0]     result,
    output logic [DATA_W/8-1:0]   flags_out,
    output logic                  illegal
);
    localparam int B_LANES = DATA_W / 8;
    localparam int H_LANES = DATA_W / 16;

    lane_op_e          op_e;
    op_kind_e          kind_e;
    logic              is_half;
    logic [DATA_W-1:0] opb;
    logic [DATA_W-1:0] byte_y, half_y, alu_y;
    logic [DATA_W-1:0] pick_b, pick_h, pick_y;
    logic [B_LANES-1:0] byte_ok, bflag;
    logic [H_LANES-1:0] half_ok, hflag;
    logic [B_LANES-1:0] flags_c;
    logic               alu_legal;

    // Decode the control fields into typed form.
    always_comb begin
        op_e    = lane_op_e'(opcode);
        kind_e  = op_kind_e'(op_kind);
        is_half = fmtsel[0];
    end

    simd_operand_sel #(
        .DATA_W (DATA_W),
        .IMM_W  (IMM_W)
    ) opsel_i (
        .fmtsel (fmtsel),
        .vec    (src_b),
        .imm    (imm),
        .opb    (opb)
    );

    for (genvar g = 0; g < B_LANES; g++) begin : g_byte
        simd_byte_lane lane_i (
            .op    (op_e),
            .a     (src_a[g*8 +: 8]),
            .b     (opb[g*8 +: 8]),
            .y     (byte_y[g*8 +: 8]),
            .legal (byte_ok[g])
        );
        assign bflag[g] = (cond_eq && (src_a[g*8 +: 8] == opb[g*8 +: 8])) ||
                          (cond_lt && (src_a[g*8 +: 8] <  opb[g*8 +: 8]));
        assign pick_b[g*8 +: 8] = (flag_in[g] == pick_tf) ? src_a[g*8 +: 8]
                                                          : opb[g*8 +: 8];
    end

    for (genvar g = 0; g < H_LANES; g++) begin : g_half
        simd_half_lane lane_i (
            .op    (op_e),
            .a     (src_a[g*16 +: 16]),
            .b     (opb[g*16 +: 16]),
            .y     (half_y[g*16 +: 16]),
            .legal (half_ok[g])
        );
        assign hflag[g] = (cond_eq && (src_a[g*16 +: 16] == opb[g*16 +: 16])) ||
                          (cond_lt && ($signed(src_a[g*16 +: 16]) <
                                       $signed(opb[g*16 +: 16])));
        assign pick_h[g*16 +: 16] = (flag_in[g] == pick_tf) ? src_a[g*16 +: 16]
                                                            : opb[g*16 +: 16];
    end

    // Select the outcome matching the lane format.
    always_comb begin
        alu_y     = is_half ? half_y : byte_y;
        alu_legal = is_half ? (&half_ok) : (&byte_ok);
        pick_y    = is_half ? pick_h : pick_b;
        flags_c   = is_half ? {{(B_LANES-H_LANES){1'b0}}, hflag} : bflag;
    end

    // Output register stage: update only the state the operation owns.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            result    <= '0;
            flags_out <= '0;
            illegal   <= 1'b0;
        end else begin
            out_valid <= in_valid;
            illegal   <= 1'b0;
            if (in_valid) begin
                case (kind_e)
                    K_ALU: begin
                        if (alu_legal) result  <= alu_y;
                        else           illegal <= 1'b1;
                    end
                    K_CMP:   flags_out <= flags_c;
                    K_PICK:  result    <= pick_y;
                    default: ;
                endcase
            end
        end
    end

    // R1: valid is delayed by exactly one stage.
    assert_valid_follows_R1: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    // R11: an undefined opcode leaves the result register untouched.
    assert_illegal_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        illegal |-> result == $past(result));

    // R11: arithmetic shift right is undefined in byte mode.
    assert_byte_sra_illegal_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op_kind == 2'd0 && !fmtsel[0] && opcode == 4'd12) |=> illegal);

    // R12: only a compare moves the flags.
    assert_flags_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op_kind != 2'd1) |=> $stable(flags_out));

    // R12: halfword compare clears the flags above the four lanes.
    assert_half_cmp_upper_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op_kind == 2'd1 && fmtsel[0]) |=>
        flags_out[B_LANES-1:H_LANES] == '0);

    // R13: when every flag matches, pick returns operand A.
    assert_pick_all_a_R13: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op_kind == 2'd2 && flag_in == {B_LANES{pick_tf}}) |=>
        result == $past(src_a));

    // R3: full-vector source with no matching flag returns src_b.
    assert_pick_vec_src_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op_kind == 2'd2 && fmtsel[4:3] == 2'b10 &&
         flag_in == {B_LANES{~pick_tf}}) |=> result == $past(src_b));

endmodule

// File: tb/simd_lane_alu_tb.sv
// Self-checking bench: directed corners plus seeded random stimulus.
module simd_lane_alu_tb_top;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        in_valid;
    logic [1:0]  op_kind;
    logic [3:0]  opcode;
    logic [4:0]  fmtsel;
    logic [63:0] src_a, src_b;
    logic [4:0]  imm;
    logic        cond_eq, cond_lt;
    logic [7:0]  flag_in;
    logic        pick_tf;
    logic        out_valid;
    logic [63:0] result;
    logic [7:0]  flags_out;
    logic        illegal;

    int total = 0;
    int bad   = 0;
    bit finished = 1'b0;

    logic [63:0] exp_res   = '0;
    logic [7:0]  exp_flags = '0;

    always #5 clk = ~clk;

    simd_lane_alu dut_i (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op_kind(op_kind),
        .opcode(opcode), .fmtsel(fmtsel), .src_a(src_a), .src_b(src_b),
        .imm(imm), .cond_eq(cond_eq), .cond_lt(cond_lt), .flag_in(flag_in),
        .pick_tf(pick_tf), .out_valid(out_valid), .result(result),
        .flags_out(flags_out), .illegal(illegal)
    );

    task automatic check(input bit ok, input string req, input logic [63:0] act,
                         input logic [63:0] expv);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, expv);
        end
    endtask

    function automatic logic [63:0] ref_opb(input logic [4:0] f, input logic [63:0] v,
                                            input logic [4:0] im);
        logic [63:0] r;
        int idx;
        if (!f[4]) begin
            if (f[0]) begin idx = int'(f[3:2]); r = {4{v[idx*16 +: 16]}}; end
            else      begin idx = int'(f[3:1]); r = {8{v[idx*8 +: 8]}}; end
        end else if (!f[3]) r = v;
        else if (f[0])      r = {4{11'b0, im}};
        else                r = {8{3'b0, im}};
        return r;
    endfunction

    function automatic logic [7:0] ref_b(input int op, input int a, input int b,
                                         output bit ok);
        int r = 0;
        ok = 1'b1;
        case (op)
            0: r = a & b;
            1: r = ~(a | b) & 255;
            2: r = a | b;
            3: r = a ^ b;
            4: r = (a << (b % 8)) & 255;
            5: r = a >> (b % 8);
            6: begin r = a + b; if (r > 255) r = 255; end
            7: begin r = a - b; if (r < 0) r = 0; end
            8: r = (a < b) ? a : b;
            9: r = (a > b) ? a : b;
            10: begin r = a * b; if (r > 255) r = 255; end
            13: r = (a > b) ? a - b : b - a;
            14: r = (a + b + 1) / 2;
            default: ok = 1'b0;
        endcase
        return r[7:0];
    endfunction

    function automatic int clamp16(input int v);
        if (v > 32767) return 32767;
        if (v < -32768) return -32768;
        return v;
    endfunction

    function automatic logic [15:0] ref_h(input int op, input int a, input int b,
                                          output bit ok);
        int r = 0;
        int s = b & 15;
        ok = 1'b1;
        case (op)
            0: r = a & b;
            1: r = ~(a | b);
            2: r = a | b;
            3: r = a ^ b;
            4: r = a << s;
            5: r = (a & 65535) >> s;
            12: r = a >>> s;
            6: r = clamp16(a + b);
            7: r = clamp16(a - b);
            8: r = (a < b) ? a : b;
            9: r = (a > b) ? a : b;
            10: r = clamp16(a * b);
            11: r = (a == 0) ? 0 : (a > 0) ? b : clamp16(-b);
            default: ok = 1'b0;
        endcase
        return r[15:0];
    endfunction

    function automatic string req_of(input int op);
        case (op)
            0, 1, 2, 3: return "R5";
            4, 5, 12:   return "R6";
            6, 7, 10:   return "R7";
            8, 9:       return "R8";
            11:         return "R9";
            default:    return "R10";
        endcase
    endfunction

    // Apply one operation, advance one cycle, check all outputs.
    task automatic run(input int kind, input int op, input logic [4:0] f,
                       input logic [63:0] a, input logic [63:0] v, input logic [4:0] im,
                       input bit ce, input bit cl, input logic [7:0] fl, input bit tf,
                       input string tag);
        logic [63:0] b2, y;
        logic [7:0]  fx;
        bit ok, ill;
        string t;
        b2 = ref_opb(f, v, im);
        y = '0; fx = '0; ok = 1'b1;
        for (int i = 0; i < 8; i++) begin
            if (!f[0]) begin
                y[i*8 +: 8] = ref_b(op, int'(a[i*8 +: 8]), int'(b2[i*8 +: 8]), ok);
                fx[i] = (ce && a[i*8 +: 8] == b2[i*8 +: 8]) ||
                        (cl && a[i*8 +: 8] < b2[i*8 +: 8]);
            end else if (i < 4) begin
                y[i*16 +: 16] = ref_h(op, int'($signed(a[i*16 +: 16])),
                                      int'($signed(b2[i*16 +: 16])), ok);
                fx[i] = (ce && a[i*16 +: 16] == b2[i*16 +: 16]) ||
                        (cl && $signed(a[i*16 +: 16]) < $signed(b2[i*16 +: 16]));
            end
        end
        ill = 1'b0;
        t = tag;
        if (kind == 0) begin
            if (ok) exp_res = y;
            else begin ill = 1'b1; t = "R11"; end
        end else if (kind == 1) exp_flags = fx;
        else if (kind == 2) begin
            for (int i = 0; i < 8; i++) begin
                if (!f[0]) exp_res[i*8 +: 8] = (fl[i] == tf) ? a[i*8 +: 8] : b2[i*8 +: 8];
                else if (i < 4)
                    exp_res[i*16 +: 16] = (fl[i] == tf) ? a[i*16 +: 16] : b2[i*16 +: 16];
            end
        end
        if (t == "") t = (kind == 0) ? req_of(op) : (kind == 1) ? "R12" : (kind == 2) ? "R13" : "R1";
        in_valid = 1'b1; op_kind = 2'(kind); opcode = 4'(op); fmtsel = f;
        src_a = a; src_b = v; imm = im; cond_eq = ce; cond_lt = cl;
        flag_in = fl; pick_tf = tf;
        @(negedge clk);
        check(out_valid == 1'b1, "R1", 64'(out_valid), 64'd1);
        check(result == exp_res, t, result, exp_res);
        check(flags_out == exp_flags, (kind == 1) ? t : "R12", 64'(flags_out), 64'(exp_flags));
        check(illegal == ill, "R11", 64'(illegal), 64'(ill));
    endtask

    initial begin
        #(200000 * 10);
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        rst_n = 1'b0; in_valid = 1'b0; op_kind = 2'd0; opcode = 4'd0; fmtsel = 5'd0;
        src_a = '0; src_b = '0; imm = '0; cond_eq = 1'b0; cond_lt = 1'b0;
        flag_in = '0; pick_tf = 1'b0;
        repeat (3) @(negedge clk);
        // R1: reset state
        check(result == 64'd0 && flags_out == 8'd0 && illegal == 1'b0 && out_valid == 1'b0,
              "R1", result, 64'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check(out_valid == 1'b0, "R1", 64'(out_valid), 64'd0);

        // R7: byte add saturates, byte sub clamps at 0 (vector source)
        run(0, 6, 5'b10000, 64'hC8C8_C8C8_C8C8_0102, 64'h6464_6464_6464_0101, 5'd0, 0, 0, 8'h00, 0, "R7");
        run(0, 7, 5'b10000, 64'h0505_0505_0505_0505, 64'h0909_0909_0909_0101, 5'd0, 0, 0, 8'h00, 0, "R7");
        // R7: halfword multiply saturates both ways
        run(0, 10, 5'b10001, 64'h7FFF_8000_0100_FFFF, 64'h0002_0002_0100_0003, 5'd0, 0, 0, 8'h00, 0, "R7");
        // R9: negation of -32768 gives +32767, zero and positive cases
        run(0, 11, 5'b10001, 64'hFFFF_0000_0005_8000, 64'h8000_1234_ABCD_0007, 5'd0, 0, 0, 8'h00, 0, "R9");
        // R4: byte element 5 broadcast, halfword element 2 broadcast
        run(0, 2, 5'b01010, 64'h0, 64'h0011_5A33_4455_6677, 5'd0, 0, 0, 8'h00, 0, "R4");
        run(0, 2, 5'b01001, 64'h0, 64'h1111_2222_3333_4444, 5'd0, 0, 0, 8'h00, 0, "R4");
        // R3/R6: immediate source, shift counts wrap
        run(0, 4, 5'b11000, 64'h0101_0101_0101_0101, 64'hFFFF, 5'd11, 0, 0, 8'h00, 0, "R6");
        run(0, 12, 5'b11001, 64'h8000_4000_F000_0F00, 64'h0, 5'd20, 0, 0, 8'h00, 0, "R6");
        // R10: byte average at the top of range, absolute difference
        run(0, 14, 5'b10000, 64'hFFFF_0001_0203_0405, 64'hFFFE_0000_0302_0504, 5'd0, 0, 0, 8'h00, 0, "R10");
        run(0, 13, 5'b10000, 64'h00FF_1020_3040_5060, 64'hFF00_2010_4030_6050, 5'd0, 0, 0, 8'h00, 0, "R10");
        // R11: format-only opcodes in the wrong format hold the result
        run(0, 12, 5'b10000, 64'h1234, 64'h5678, 5'd0, 0, 0, 8'h00, 0, "R11");
        run(0, 14, 5'b10001, 64'h1234, 64'h5678, 5'd0, 0, 0, 8'h00, 0, "R11");
        // R12: signed halfword compare, upper flags clear
        run(1, 0, 5'b10001, 64'hFFFF_0001_0005_8000, 64'h0001_0001_0004_7FFF, 5'd0, 1, 1, 8'h00, 0, "R12");
        run(1, 0, 5'b10000, 64'hFF01_0203_0405_0607, 64'h01FF_0303_0505_0000, 5'd0, 0, 1, 8'h00, 0, "R12");
        // R13: pick by flags, both polarities
        run(2, 0, 5'b10000, 64'hAAAA_AAAA_AAAA_AAAA, 64'h5555_5555_5555_5555, 5'd0, 0, 0, 8'hA5, 1, "R13");
        run(2, 0, 5'b10001, 64'hAAAA_BBBB_CCCC_DDDD, 64'h1111_2222_3333_4444, 5'd0, 0, 0, 8'h06, 0, "R13");
        // R1/R2: kind 3 touches nothing; same opcode both formats
        run(3, 6, 5'b10000, 64'hFFFF, 64'hFFFF, 5'd0, 1, 1, 8'hFF, 1, "R1");
        run(0, 8, 5'b10000, 64'h8001_0000_0000_0000, 64'h7FFF_0000_0000_0000, 5'd0, 0, 0, 8'h00, 0, "R2");
        run(0, 8, 5'b10001, 64'h8001_0000_0000_0000, 64'h7FFF_0000_0000_0000, 5'd0, 0, 0, 8'h00, 0, "R2");

        for (int n = 0; n < 3000; n++) begin
            int k;
            k = int'($urandom % 10);
            k = (k < 6) ? 0 : (k < 8) ? 1 : (k < 9) ? 2 : 3;
            run(k, int'($urandom % 16), 5'($urandom), {$urandom, $urandom},
                {$urandom, $urandom}, 5'($urandom), 1'($urandom), 1'($urandom),
                8'($urandom), 1'($urandom), "");
        end

        in_valid = 1'b0;
        @(negedge clk);
        check(out_valid == 1'b0, "R1", 64'(out_valid), 64'd0);

        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule